// File: doc/BRIEF.md
# Pointer-Addressed Serial Register Target for a Power Controller

This block is the two-wire serial target that gives a host processor access to the control and status registers of a multi-rail display power controller. It watches the open-drain clock and data lines through a faster system clock, recognises its own 7-bit device address, and answers only to that address. A one-byte pointer chooses the internal register. Supported transfers are single-byte writes, single-byte reads and two-byte reads of the temperature registers, most significant byte first.

The pointer is a stored register. It survives STOP conditions, so the host can poll a register repeatedly with a bare read. A new register is read by sending the pointer in a write phase and then a repeated START followed by a read header. Each register has its own access rights and power-on value. A store-command register triggers copies of the calibration value or of the eight sequencing timing registers into non-volatile storage. Each copy has a limited budget, and the target answers with NACK once that budget is spent. The target also answers with NACK when a timing copy is requested before all eight timing registers have been programmed.

If the data line stays low for longer than the bus timeout, the interface drops back to idle and lets go of the line. This recovers a bus that a master abandoned in the middle of a read.

Top module: `pwr_i2c_target`

## Requirements
- R1: The target acknowledges only the header whose upper seven bits equal DEV_ADDR (default 7'b1001000); bit 0 of the header is 1 for read and 0 for write. A header with any other address gets no acknowledge, and the bytes that follow it change no register.
- R2: A write transfer is header, pointer byte, then one data byte, each acknowledged; the data lands in the register the pointer selects, and only pointer bits 4:0 select the register (bits 7:5 are ignored).
- R3: The pointer keeps its last value across STOP; a read header with no pointer byte returns the register at the kept pointer, and header-write, pointer, repeated START, header-read reads a newly chosen register.
- R4: After reset the pointer is 0x00 and the registers hold: 0x01 = 00h, 0x06 = 00h, 0x07 = 4Dh, 0x08 = FFh, 0x09 = 00h, 0x0B = 0Ah, 0x0F = 04h, and timing registers 0x10..0x17 = 1Eh, 3Ch, 5Ah, 78h, 1Eh, 3Ch, 5Ah, 78h.
- R5: Registers 0x00 (external temperature) and 0x04 (internal temperature) are 16 bits wide. They return bits 15:8 first; after the master acknowledges, they return bits 7:0. A master NACK after the first byte ends the read.
- R6: Read-only registers 0x00, 0x04, 0x05, 0x06, 0x07 and 0x0A, and addresses that map to no register, acknowledge writes but keep their contents. Reads of the write-only store register 0x0C and of unmapped addresses return 00h.
- R7: Writing 0x0C with bit 0 set pulses dvrStore for one cycle. At most DVR_STORE_MAX such stores are accepted; after that, a request with bit 0 set gets NACK and produces no pulse.
- R8: Writing 0x0C with bit 1 set pulses timingStore for one cycle. The request is accepted only when every timing register 0x10..0x17 has been written since reset and fewer than TIM_STORE_MAX timing stores have been accepted; otherwise it gets NACK and produces no pulse.
- R9: When SDA stays low for TIMEOUT_CYCLES system clocks, the target releases SDA and returns to idle, and the next transfer works normally.
- R10: The target starts pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| sdaDriveLow | output | 1 | 1 pulls the data line low, 0 releases it |
| extTemp | input | 16 | External temperature value, register 0x00 |
| intTemp | input | 16 | Internal temperature value, register 0x04 |
| statusIn | input | 8 | Status value, register 0x05 |
| faultIn | input | 8 | Fault value, register 0x0A |
| cfgOut | output | 8 | Configuration register 0x01 |
| dvrOut | output | 8 | Common-electrode DAC setting, register 0x08 |
| enableOut | output | 8 | Output enable register 0x09 |
| railOut | output | 8 | Positive rail set-point register 0x0B |
| rateOut | output | 8 | Conversion rate register 0x0F |
| timingOut | output | 64 | Timing registers 0x10..0x17, register 0x10 in bits 7:0 |
| dvrStore | output | 1 | One-cycle request to store the DAC setting |
| timingStore | output | 1 | One-cycle request to store the timing registers |

## Verification
The bench builds the target with DVR_STORE_MAX = 4, TIM_STORE_MAX = 2 and TIMEOUT_CYCLES = 500, and keeps the default address. With the small store budgets, the bench can use up both budgets and see the NACK that follows within a few dozen transfers. The short timeout lets a master that stalls mid-read, with the target holding the data line low, reach the recovery path in a few hundred cycles. Because the bench clocks SCL slowly against the system clock, every SDA change made by the target can be checked against the level of SCL.

// File: rtl/pwr_i2c_pkg.sv
package pwr_i2c_pkg;
  localparam int PTR_W       = 5;
  localparam int TIMING_REGS = 8;

  localparam logic [PTR_W-1:0] ADR_EXT   = 5'h00;
  localparam logic [PTR_W-1:0] ADR_CFG   = 5'h01;
  localparam logic [PTR_W-1:0] ADR_INT   = 5'h04;
  localparam logic [PTR_W-1:0] ADR_STAT  = 5'h05;
  localparam logic [PTR_W-1:0] ADR_REV   = 5'h06;
  localparam logic [PTR_W-1:0] ADR_ID    = 5'h07;
  localparam logic [PTR_W-1:0] ADR_DVR   = 5'h08;
  localparam logic [PTR_W-1:0] ADR_EN    = 5'h09;
  localparam logic [PTR_W-1:0] ADR_FLT   = 5'h0A;
  localparam logic [PTR_W-1:0] ADR_RAIL  = 5'h0B;
  localparam logic [PTR_W-1:0] ADR_STORE = 5'h0C;
  localparam logic [PTR_W-1:0] ADR_RATE  = 5'h0F;
  localparam logic [PTR_W-1:0] ADR_TIM0  = 5'h10;

  localparam logic [7:0] RST_CFG  = 8'h00;
  localparam logic [7:0] RST_DVR  = 8'hFF;
  localparam logic [7:0] RST_EN   = 8'h00;
  localparam logic [7:0] RST_RAIL = 8'h0A;
  localparam logic [7:0] RST_RATE = 8'h04;
  localparam logic [7:0] VAL_REV  = 8'h00;
  localparam logic [7:0] VAL_ID   = 8'h4D;
  localparam int         TIM_STEP = 30;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_PTR, ST_WDATA, ST_READ, ST_SKIP
  } busState_t;

  // strobes from the bus control to the register datapath
  typedef struct packed {
    logic       ptrLoad;
    logic       wrEn;
    logic [7:0] data;
  } busStrobe_t;
endpackage

// File: rtl/pwr_i2c_lines.sv
module pwr_i2c_lines #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaLevel,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev, sclNow, sdaNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclNow    = sclPipe[SYNC_STAGES-1];
  assign sdaNow    = sdaPipe[SYNC_STAGES-1];
  assign sdaLevel  = sdaNow;
  assign sclRise   = sclNow & ~sclPrev;
  assign sclFall   = ~sclNow & sclPrev;
  assign startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;
endmodule

// File: rtl/pwr_i2c_ctrl.sv
module pwr_i2c_ctrl
  import pwr_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR       = 7'h48,
  parameter int         TIMEOUT_CYCLES = 7_500_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdaLevel,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startSeen,
  input  logic       stopSeen,
  input  logic       refuse,
  input  logic       isWord,
  input  logic [7:0] rdHi,
  input  logic [7:0] rdLo,
  output busStrobe_t strobe,
  output logic       sdaDriveLow
);
  localparam int TO_W = $clog2(TIMEOUT_CYCLES + 1);

  busState_t   state, pendState;
  logic [3:0]  bitCnt;
  logic [7:0]  rxShift, txShift, loHold;
  logic        wordLow, masterAck, drive, active, byteDone, timeoutHit;
  logic [TO_W-1:0] lowCnt;

  assign active     = (state != ST_IDLE) && (state != ST_SKIP);
  assign byteDone   = sclFall && active && (bitCnt == 4'd8);
  assign timeoutHit = (lowCnt == TO_W'(TIMEOUT_CYCLES));

  assign strobe.data    = rxShift;
  assign strobe.ptrLoad = byteDone && (state == ST_PTR);
  assign strobe.wrEn    = byteDone && (state == ST_WDATA) && !refuse;
  assign sdaDriveLow    = drive;

  always_ff @(posedge clk) begin
    if (!rstN)          lowCnt <= '0;
    else if (sdaLevel)  lowCnt <= '0;
    else if (!timeoutHit) lowCnt <= lowCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      pendState <= ST_IDLE;
      bitCnt    <= '0;
      rxShift   <= '0;
      txShift   <= '0;
      loHold    <= '0;
      wordLow   <= 1'b0;
      masterAck <= 1'b0;
      drive     <= 1'b0;
    end else if (timeoutHit) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      drive  <= 1'b0;
    end else if (startSeen) begin
      state   <= ST_ADDR;
      bitCnt  <= '0;
      drive   <= 1'b0;
      wordLow <= 1'b0;
    end else if (stopSeen) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      drive  <= 1'b0;
    end else if (active && sclRise) begin
      if (bitCnt < 4'd8) begin
        rxShift <= {rxShift[6:0], sdaLevel};
        bitCnt  <= bitCnt + 1'b1;
      end else begin
        masterAck <= !sdaLevel;
        bitCnt    <= 4'd9;
      end
    end else if (active && sclFall) begin
      if (bitCnt == 4'd8) begin
        case (state)
          ST_ADDR: begin
            if (rxShift[7:1] == DEV_ADDR) begin
              drive     <= 1'b1;
              pendState <= rxShift[0] ? ST_READ : ST_PTR;
            end else begin
              drive     <= 1'b0;
              pendState <= ST_SKIP;
            end
          end
          ST_PTR: begin
            drive     <= 1'b1;
            pendState <= ST_WDATA;
          end
          ST_WDATA: begin
            drive     <= !refuse;
            pendState <= ST_SKIP;
          end
          default: drive <= 1'b0;
        endcase
      end else if (bitCnt == 4'd9) begin
        bitCnt <= '0;
        drive  <= 1'b0;
        if (state == ST_READ) begin
          if (masterAck && isWord && !wordLow) begin
            wordLow <= 1'b1;
            txShift <= loHold;
            drive   <= !loHold[7];
          end else begin
            state <= ST_SKIP;
          end
        end else begin
          state <= pendState;
          if (pendState == ST_READ) begin
            txShift <= rdHi;
            loHold  <= rdLo;
            wordLow <= 1'b0;
            drive   <= !rdHi[7];
          end
        end
      end else if (bitCnt != 4'd0 && state == ST_READ) begin
        txShift <= {txShift[6:0], 1'b0};
        drive   <= !txShift[6];
      end
    end
  end
endmodule

// File: rtl/pwr_i2c_regs.sv
module pwr_i2c_regs
  import pwr_i2c_pkg::*;
#(
  parameter int DVR_STORE_MAX = 30,
  parameter int TIM_STORE_MAX = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  busStrobe_t               strobe,
  input  logic [15:0]              extTemp,
  input  logic [15:0]              intTemp,
  input  logic [7:0]               statusIn,
  input  logic [7:0]               faultIn,
  output logic                     refuse,
  output logic                     isWord,
  output logic [7:0]               rdHi,
  output logic [7:0]               rdLo,
  output logic [7:0]               cfgOut,
  output logic [7:0]               dvrOut,
  output logic [7:0]               enableOut,
  output logic [7:0]               railOut,
  output logic [7:0]               rateOut,
  output logic [TIMING_REGS*8-1:0] timingOut,
  output logic                     dvrStore,
  output logic                     timingStore
);
  localparam int DC_W = $clog2(DVR_STORE_MAX + 1);
  localparam int TC_W = $clog2(TIM_STORE_MAX + 1);
  localparam int TI_W = $clog2(TIMING_REGS);

  logic [PTR_W-1:0]       ptr;
  logic [7:0]             timReg [TIMING_REGS];
  logic [TIMING_REGS-1:0] timSeen;
  logic [DC_W-1:0]        dvrCnt;
  logic [TC_W-1:0]        timCnt;
  logic                   storeSel, inTimRange, dvrFull, timBlocked;
  logic [PTR_W-1:0]       timOff;

  assign storeSel   = (ptr == ADR_STORE);
  assign timOff     = ptr - ADR_TIM0;
  assign inTimRange = (ptr >= ADR_TIM0) && (32'(ptr) < 32'(ADR_TIM0) + TIMING_REGS);
  assign dvrFull    = (dvrCnt == DC_W'(DVR_STORE_MAX));
  assign timBlocked = (timCnt == TC_W'(TIM_STORE_MAX)) || !(&timSeen);
  assign refuse     = storeSel && ((strobe.data[0] && dvrFull) ||
                                   (strobe.data[1] && timBlocked));
  assign isWord     = (ptr == ADR_EXT) || (ptr == ADR_INT);

  always_ff @(posedge clk) begin
    if (!rstN)               ptr <= ADR_EXT;
    else if (strobe.ptrLoad) ptr <= strobe.data[PTR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgOut    <= RST_CFG;
      dvrOut    <= RST_DVR;
      enableOut <= RST_EN;
      railOut   <= RST_RAIL;
      rateOut   <= RST_RATE;
    end else if (strobe.wrEn) begin
      case (ptr)
        ADR_CFG:  cfgOut    <= strobe.data;
        ADR_DVR:  dvrOut    <= strobe.data;
        ADR_EN:   enableOut <= strobe.data;
        ADR_RAIL: railOut   <= strobe.data;
        ADR_RATE: rateOut   <= strobe.data;
        default:  ;
      endcase
    end
  end

  for (genvar i = 0; i < TIMING_REGS; i++) begin : g_tim
    localparam logic [7:0] RST_VAL = 8'(((i % 4) + 1) * TIM_STEP);
    logic hit;
    assign hit = strobe.wrEn && inTimRange && (timOff[TI_W-1:0] == TI_W'(i));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        timReg[i]  <= RST_VAL;
        timSeen[i] <= 1'b0;
      end else if (hit) begin
        timReg[i]  <= strobe.data;
        timSeen[i] <= 1'b1;
      end
    end
    assign timingOut[i*8 +: 8] = timReg[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dvrCnt      <= '0;
      timCnt      <= '0;
      dvrStore    <= 1'b0;
      timingStore <= 1'b0;
    end else begin
      dvrStore    <= strobe.wrEn && storeSel && strobe.data[0];
      timingStore <= strobe.wrEn && storeSel && strobe.data[1];
      if (strobe.wrEn && storeSel && strobe.data[0]) dvrCnt <= dvrCnt + 1'b1;
      if (strobe.wrEn && storeSel && strobe.data[1]) timCnt <= timCnt + 1'b1;
    end
  end

  always_comb begin
    rdHi = 8'h00;
    rdLo = 8'h00;
    case (ptr)
      ADR_EXT:  {rdHi, rdLo} = extTemp;
      ADR_INT:  {rdHi, rdLo} = intTemp;
      ADR_CFG:  rdHi = cfgOut;
      ADR_STAT: rdHi = statusIn;
      ADR_REV:  rdHi = VAL_REV;
      ADR_ID:   rdHi = VAL_ID;
      ADR_DVR:  rdHi = dvrOut;
      ADR_EN:   rdHi = enableOut;
      ADR_FLT:  rdHi = faultIn;
      ADR_RAIL: rdHi = railOut;
      ADR_RATE: rdHi = rateOut;
      default:  if (inTimRange) rdHi = timReg[timOff[TI_W-1:0]];
    endcase
  end
endmodule

// File: rtl/pwr_i2c_target.sv
module pwr_i2c_target
  import pwr_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR       = 7'h48,
  parameter int         TIMEOUT_CYCLES = 7_500_000,
  parameter int         DVR_STORE_MAX  = 30,
  parameter int         TIM_STORE_MAX  = 3,
  parameter int         SYNC_STAGES    = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sclIn,
  input  logic                     sdaIn,
  output logic                     sdaDriveLow,
  input  logic [15:0]              extTemp,
  input  logic [15:0]              intTemp,
  input  logic [7:0]               statusIn,
  input  logic [7:0]               faultIn,
  output logic [7:0]               cfgOut,
  output logic [7:0]               dvrOut,
  output logic [7:0]               enableOut,
  output logic [7:0]               railOut,
  output logic [7:0]               rateOut,
  output logic [TIMING_REGS*8-1:0] timingOut,
  output logic                     dvrStore,
  output logic                     timingStore
);
  logic       sdaLevel, sclRise, sclFall, startSeen, stopSeen;
  logic       refuse, isWord;
  logic [7:0] rdHi, rdLo;
  busStrobe_t strobe;

  pwr_i2c_lines #(.SYNC_STAGES(SYNC_STAGES)) u_lines (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaLevel(sdaLevel), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen)
  );

  pwr_i2c_ctrl #(.DEV_ADDR(DEV_ADDR), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sdaLevel(sdaLevel), .sclRise(sclRise),
    .sclFall(sclFall), .startSeen(startSeen), .stopSeen(stopSeen),
    .refuse(refuse), .isWord(isWord), .rdHi(rdHi), .rdLo(rdLo),
    .strobe(strobe), .sdaDriveLow(sdaDriveLow)
  );

  pwr_i2c_regs #(.DVR_STORE_MAX(DVR_STORE_MAX), .TIM_STORE_MAX(TIM_STORE_MAX)) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .extTemp(extTemp),
    .intTemp(intTemp), .statusIn(statusIn), .faultIn(faultIn),
    .refuse(refuse), .isWord(isWord), .rdHi(rdHi), .rdLo(rdLo),
    .cfgOut(cfgOut), .dvrOut(dvrOut), .enableOut(enableOut),
    .railOut(railOut), .rateOut(rateOut), .timingOut(timingOut),
    .dvrStore(dvrStore), .timingStore(timingStore)
  );
endmodule

// File: rtl/pwr_i2c_checker.sv
module pwr_i2c_checker #(
  parameter int TIMEOUT_CYCLES = 7_500_000,
  parameter int DVR_STORE_MAX  = 30,
  parameter int TIM_STORE_MAX  = 3
) (
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       sdaIn,
  input logic       sdaDriveLow,
  input logic       dvrStore,
  input logic       timingStore,
  input logic [7:0] dvrOut,
  input logic [7:0] railOut
);
  localparam int LR_W = $clog2(TIMEOUT_CYCLES + 16) + 1;
  localparam int DC_W = $clog2(DVR_STORE_MAX + 2);
  localparam int TC_W = $clog2(TIM_STORE_MAX + 2);

  logic [LR_W-1:0] lowRun;
  logic [DC_W-1:0] dvrSeen;
  logic [TC_W-1:0] timSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowRun  <= '0;
      dvrSeen <= '0;
      timSeen <= '0;
    end else begin
      if (sdaIn) lowRun <= '0;
      else if (lowRun != '1) lowRun <= lowRun + 1'b1;
      if (dvrStore) dvrSeen <= dvrSeen + 1'b1;
      if (timingStore) timSeen <= timSeen + 1'b1;
    end
  end

  assert_reset_values_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (dvrOut == 8'hFF && railOut == 8'h0A));

  assert_dvr_budget_R7: assert property (@(posedge clk) disable iff (!rstN)
    32'(dvrSeen) <= DVR_STORE_MAX);

  assert_dvr_single_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    dvrStore |=> !dvrStore);

  assert_tim_budget_R8: assert property (@(posedge clk) disable iff (!rstN)
    32'(timSeen) <= TIM_STORE_MAX);

  assert_timeout_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    (32'(lowRun) > TIMEOUT_CYCLES + 6) |-> !sdaDriveLow);

  assert_drive_on_scl_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> !sclIn);
endmodule

bind pwr_i2c_target pwr_i2c_checker #(
  .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
  .DVR_STORE_MAX(DVR_STORE_MAX),
  .TIM_STORE_MAX(TIM_STORE_MAX)
) u_checker (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
  .sdaDriveLow(sdaDriveLow), .dvrStore(dvrStore), .timingStore(timingStore),
  .dvrOut(dvrOut), .railOut(railOut)
);

// File: tb/pwr_i2c_target_bench.sv
module pwr_i2c_target_bench;
  localparam int DVR_MAX = 4;
  localparam int TIM_MAX = 2;
  localparam int TMO     = 500;
  localparam int H       = 12;
  localparam int Q       = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclM = 1'b1;
  logic        sdaM = 1'b1;
  logic        sdaBus, sdaDriveLow;
  logic [15:0] extTemp  = 16'h1A2B;
  logic [15:0] intTemp  = 16'h8C41;
  logic [7:0]  statusIn = 8'h5C;
  logic [7:0]  faultIn  = 8'h03;
  logic [7:0]  cfgOut, dvrOut, enableOut, railOut, rateOut;
  logic [63:0] timingOut;
  logic        dvrStore, timingStore;

  int checks = 0;
  int fails = 0;
  int dvrPulses = 0;
  int timPulses = 0;
  int earlyDrive = 0;
  bit done = 1'b0;
  logic prevDrive = 1'b0;

  assign sdaBus = sdaM & ~sdaDriveLow;

  always #4 clk = ~clk;

  pwr_i2c_target #(
    .TIMEOUT_CYCLES(TMO), .DVR_STORE_MAX(DVR_MAX), .TIM_STORE_MAX(TIM_MAX)
  ) u_pwr_i2c_target (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaDriveLow(sdaDriveLow), .extTemp(extTemp), .intTemp(intTemp),
    .statusIn(statusIn), .faultIn(faultIn), .cfgOut(cfgOut), .dvrOut(dvrOut),
    .enableOut(enableOut), .railOut(railOut), .rateOut(rateOut),
    .timingOut(timingOut), .dvrStore(dvrStore), .timingStore(timingStore)
  );

  always @(posedge clk) begin
    if (dvrStore) dvrPulses++;
    if (timingStore) timPulses++;
    if (sdaDriveLow && !prevDrive && sclM) earlyDrive++;
    prevDrive <= sdaDriveLow;
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; sclM = 1'b1; w(H);
    sdaM = 1'b0; w(H);
    sclM = 1'b0; w(Q);
  endtask

  task automatic busRestart();
    sdaM = 1'b1; w(Q);
    sclM = 1'b1; w(H);
    sdaM = 1'b0; w(H);
    sclM = 1'b0; w(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; w(Q);
    sclM = 1'b1; w(H);
    sdaM = 1'b1; w(H);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; w(Q);
      sclM = 1'b1; w(H);
      sclM = 1'b0; w(Q);
    end
    sdaM = 1'b1; w(Q);
    sclM = 1'b1; w(H / 2);
    ack = !sdaBus;
    w(H / 2);
    sclM = 1'b0; w(Q);
  endtask

  task automatic recvByte(output logic [7:0] b, input bit ackIt);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(Q);
      sclM = 1'b1; w(H / 2);
      b[i] = sdaBus;
      w(H / 2);
      sclM = 1'b0; w(Q);
    end
    sdaM = ackIt ? 1'b0 : 1'b1; w(Q);
    sclM = 1'b1; w(H);
    sclM = 1'b0; w(Q);
    sdaM = 1'b1;
  endtask

  task automatic writeReg(input logic [7:0] p, input logic [7:0] d,
                          output bit aA, output bit aP, output bit aD);
    busStart();
    sendByte(8'h90, aA);
    sendByte(p, aP);
    sendByte(d, aD);
    busStop();
  endtask

  task automatic readFrom(input logic [7:0] p, input bit word, output logic [15:0] v);
    bit a;
    logic [7:0] hi, lo;
    busStart();
    sendByte(8'h90, a);
    sendByte(p, a);
    busRestart();
    sendByte(8'h91, a);
    recvByte(hi, word);
    lo = 8'h00;
    if (word) recvByte(lo, 1'b0);
    busStop();
    v = word ? {hi, lo} : {8'h00, hi};
  endtask

  task automatic readLatched(input bit word, output logic [15:0] v);
    bit a;
    logic [7:0] hi, lo;
    busStart();
    sendByte(8'h91, a);
    recvByte(hi, word);
    lo = 8'h00;
    if (word) recvByte(lo, 1'b0);
    busStop();
    v = word ? {hi, lo} : {8'h00, hi};
  endtask

  task automatic testReset();
    logic [15:0] v;
    chk("R4 cfg reset", cfgOut, 8'h00);
    chk("R4 dvr reset", dvrOut, 8'hFF);
    chk("R4 enable reset", enableOut, 8'h00);
    chk("R4 rail reset", railOut, 8'h0A);
    chk("R4 rate reset", rateOut, 8'h04);
    chk("R4 timing low half reset", int'(timingOut[31:0]), 32'h785A3C1E);
    chk("R4 timing high half reset", int'(timingOut[63:32]), 32'h785A3C1E);
    chk("R10 idle release", sdaDriveLow, 0);
    readLatched(1'b1, v);
    chk("R4 R5 reset pointer word read", v, 16'h1A2B);
  endtask

  task automatic testAddress();
    bit a, b, c;
    busStart();
    sendByte(8'h92, a);
    sendByte(8'h01, b);
    sendByte(8'h77, c);
    busStop();
    chk("R1 foreign address nack", a, 0);
    chk("R1 foreign data ignored", cfgOut, 8'h00);
    writeReg(8'h01, 8'h21, a, b, c);
    chk("R1 own address ack", a, 1);
    chk("R2 pointer ack", b, 1);
    chk("R2 data ack", c, 1);
    chk("R2 cfg written", cfgOut, 8'h21);
  endtask

  task automatic testWrite();
    bit a, b, c;
    writeReg(8'hE9, 8'h3C, a, b, c);
    chk("R2 upper pointer bits ignored", enableOut, 8'h3C);
    writeReg(8'h0B, 8'h0F, a, b, c);
    chk("R2 rail written", railOut, 8'h0F);
  endtask

  task automatic testPointer();
    logic [15:0] v;
    readFrom(8'h07, 1'b0, v);
    chk("R3 repeated start read id", v, 8'h4D);
    readLatched(1'b0, v);
    chk("R3 latched pointer after stop", v, 8'h4D);
    readFrom(8'h0F, 1'b0, v);
    chk("R4 rate read", v, 8'h04);
  endtask

  task automatic testWord();
    logic [15:0] v;
    readFrom(8'h04, 1'b1, v);
    chk("R5 internal word", v, 16'h8C41);
    readFrom(8'h05, 1'b0, v);
    chk("R6 status read", v, 8'h5C);
    readFrom(8'h00, 1'b0, v);
    chk("R5 nack after upper byte", v, 8'h1A);
    readLatched(1'b1, v);
    chk("R5 word after short read", v, 16'h1A2B);
  endtask

  task automatic testAccess();
    bit a, b, c;
    logic [15:0] v;
    writeReg(8'h07, 8'h11, a, b, c);
    chk("R6 read-only write ack", c, 1);
    readLatched(1'b0, v);
    chk("R6 read-only kept", v, 8'h4D);
    writeReg(8'h06, 8'h99, a, b, c);
    readLatched(1'b0, v);
    chk("R6 revision kept", v, 8'h00);
    writeReg(8'h1F, 8'h33, a, b, c);
    chk("R6 unmapped write ack", c, 1);
    readLatched(1'b0, v);
    chk("R6 unmapped reads zero", v, 8'h00);
    readFrom(8'h0C, 1'b0, v);
    chk("R6 write-only reads zero", v, 8'h00);
    readFrom(8'h0A, 1'b0, v);
    chk("R6 fault read", v, 8'h03);
  endtask

  task automatic testDvrStore();
    bit a, b, c;
    writeReg(8'h08, 8'h77, a, b, c);
    chk("R2 dvr written", dvrOut, 8'h77);
    writeReg(8'h0C, 8'h00, a, b, c);
    chk("R7 empty store ack", c, 1);
    chk("R7 empty store no pulse", dvrPulses, 0);
    for (int k = 0; k < DVR_MAX; k++) begin
      writeReg(8'h0C, 8'h01, a, b, c);
      chk("R7 store accepted", c, 1);
      chk("R7 store pulse count", dvrPulses, k + 1);
    end
    writeReg(8'h0C, 8'h01, a, b, c);
    chk("R7 store over budget nack", c, 0);
    chk("R7 no pulse over budget", dvrPulses, DVR_MAX);
  endtask

  task automatic testTimingStore();
    bit a, b, c;
    writeReg(8'h0C, 8'h02, a, b, c);
    chk("R8 store before programming nack", c, 0);
    for (int i = 0; i < 7; i++) writeReg(8'(8'h10 + i), 8'(8'h40 + i), a, b, c);
    writeReg(8'h0C, 8'h02, a, b, c);
    chk("R8 store with one missing nack", c, 0);
    chk("R8 no pulse yet", timPulses, 0);
    writeReg(8'h17, 8'h47, a, b, c);
    chk("R8 timing values low", int'(timingOut[31:0]), 32'h43424140);
    chk("R8 timing values high", int'(timingOut[63:32]), 32'h47464544);
    for (int k = 0; k < TIM_MAX; k++) begin
      writeReg(8'h0C, 8'h02, a, b, c);
      chk("R8 timing store accepted", c, 1);
      chk("R8 timing pulse count", timPulses, k + 1);
    end
    writeReg(8'h0C, 8'h02, a, b, c);
    chk("R8 timing over budget nack", c, 0);
    chk("R8 no pulse over budget", timPulses, TIM_MAX);
  endtask

  task automatic testTimeout();
    bit a;
    logic [15:0] v;
    busStart();
    sendByte(8'h90, a);
    sendByte(8'h01, a);
    busStop();
    busStart();
    sendByte(8'h91, a);
    w(2);
    chk("R9 target holding first read bit low", sdaDriveLow, 1);
    w(TMO + 20);
    chk("R9 released after timeout", sdaDriveLow, 0);
    sdaM = 1'b0; w(Q);
    sclM = 1'b1; w(H);
    sdaM = 1'b1; w(H);
    readFrom(8'h07, 1'b0, v);
    chk("R9 bus usable after timeout", v, 8'h4D);
  endtask

  initial begin
    w(10);
    rstN = 1'b1;
    w(10);
    testReset();
    testAddress();
    testWrite();
    testPointer();
    testWord();
    testAccess();
    testDvrStore();
    testTimingStore();
    testTimeout();
    chk("R10 drive starts only with SCL low", earlyDrive, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule